// File: doc/BRIEF.md
# Prescaled Modulus Down-Counter with Underflow Flag

This block is a 16-bit down-counter stepped by a programmable clock divider. Software loads a start value through a small register port; the same value is kept as the reload value. While running, the count drops by one on every divided tick. The step that takes the count to zero raises a sticky zero flag, which can request an interrupt. In reload mode the counter restarts from the stored value on the next tick after zero. In single-shot mode it stays at zero.

The flag has two clearing schemes, chosen by the `fast_clr_en` input. With the input low, software clears the flag by writing a one to its bit. With the input high, such writes are ignored, and any read or write of the count register clears the flag instead. Registers at the port: address 0 control, address 1 flag, address 2 count (read the live count, write loads it), address 3 reload value (read only).

Top module: `mdc_top`

## Requirements
- R1: After synchronous reset, the count, the flag, the interrupt request and the control register are all zero.
- R2: Control bits [3:2] select the tick divider: 00 steps every clock, 01 every 4 clocks, 10 every 8 clocks, 11 every 16 clocks. After the run bit (control bit 0) is set, the count after k clocks equals the start value minus floor(k/N), and stops at zero.
- R3: A write to address 2 loads both the count and the reload value (read back at address 3), and restarts the divider so that the next step comes a full N clocks later.
- R4: The flag is bit 7 of address 1. It sets on the tick that moves the count from 1 to 0.
- R5: With `fast_clr_en` low, writing a word with bit 7 set to address 1 clears the flag. A write with bit 7 clear leaves the flag unchanged.
- R6: With `fast_clr_en` high, a write of one to flag bit 7 does not clear the flag.
- R7: With `fast_clr_en` high, a read strobe or a write strobe at address 2 clears the flag at that clock edge.
- R8: When the flag-setting tick and a clearing access fall on the same edge, the flag ends up set.
- R9: With control bit 1 set (reload mode), a tick at count zero reloads the stored value, so the period is the reload value plus one ticks. With bit 1 clear the count stays at zero.
- R10: The interrupt request `irq` is high exactly when the flag is set and control bit 4 is set.
- R11: A read of address 1 returns the flag in bit 7 and zero in every other bit.
- R12: With control bit 0 clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_clr_en | input | 1 | Selects clearing the flag by count access instead of write-one |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects only) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed register |
| count | output | 16 | Live counter value |
| flag | output | 1 | Sticky zero flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clearing access that falls on the exact edge where the count steps from 1 to 0, because the set must win. The bench reaches it by running the divider at one step per clock from a known load of 3. It counts the clocks since the run bit was written and times either a write-one or a count read so that its strobe edge is the third step. The divider sweep covers every divider code in the same way. The expected count at each clock is found from the clock count and the division factor.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

    localparam int ADDR_W   = 2;
    localparam int FLAG_BIT = 7;
    localparam int SEL_W    = 2;
    localparam int PCNT_W   = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL   = 2'd0,
        ADR_FLAG   = 2'd1,
        ADR_COUNT  = 2'd2,
        ADR_RELOAD = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             irq_en;
        logic [SEL_W-1:0] div_sel;
        logic             reload_mode;
        logic             run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic cnt_wr;
        logic cnt_rd;
        logic flag_w1c;
    } access_t;

    // last divider phase for a select code: N-1 with N = 1, 4, 8, 16
    function automatic logic [PCNT_W-1:0] div_last(input logic [SEL_W-1:0] sel);
        logic [PCNT_W-1:0] r;
        case (sel)
            2'd0:    r = 4'd0;
            2'd1:    r = 4'd3;
            2'd2:    r = 4'd7;
            default: r = 4'd15;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mdc_prescaler.sv
module mdc_prescaler
    import mdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);

    logic [PCNT_W-1:0] phase;
    logic [PCNT_W-1:0] last;

    assign last = div_last(div_sel);
    assign tick = run && (phase >= last);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            phase <= '0;
        end else if (phase >= last) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // R2: with a divider above one, two ticks never come back to back
    a_r2_no_double_tick: assert property (@(posedge clk) disable iff (rst)
        (tick && div_sel != 2'd0) |=> (!tick || div_sel == 2'd0));

    // R12: no tick while halted
    a_r12_halt_no_tick: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick);

endmodule

// File: rtl/mdc_counter.sv
module mdc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load_wr,
    input  logic [W-1:0] load_data,
    input  logic         reload_mode,
    output logic [W-1:0] count,
    output logic [W-1:0] reload_val,
    output logic         zero_evt
);

    localparam logic [W-1:0] ONE = W'(1);

    logic at_zero;

    assign at_zero  = (count == '0);
    assign zero_evt = tick && !load_wr && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count      <= '0;
            reload_val <= '0;
        end else if (load_wr) begin
            count      <= load_data;
            reload_val <= load_data;
        end else if (tick) begin
            if (!at_zero) begin
                count <= count - ONE;
            end else if (reload_mode) begin
                count <= reload_val;
            end
        end
    end

    // R3: a load lands in the count on the next cycle
    a_r3_load_lands: assert property (@(posedge clk) disable iff (rst)
        load_wr |=> (count == $past(load_data)));

    // R2: without tick or load the count is frozen
    a_r2_stable_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (!load_wr && !tick) |=> $stable(count));

    // R9: single-shot mode parks at zero
    a_r9_oneshot_parks: assert property (@(posedge clk) disable iff (rst)
        (at_zero && !reload_mode && !load_wr) |=> (count == '0));

    // R9: reload mode restarts from the stored value
    a_r9_reload_restarts: assert property (@(posedge clk) disable iff (rst)
        (at_zero && reload_mode && tick && !load_wr) |=> (count == $past(reload_val)));

endmodule

// File: rtl/mdc_flag.sv
module mdc_flag
    import mdc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    set_evt,
    input  logic    fast_clr_en,
    input  access_t acc,
    output logic    flag
);

    logic clr;

    always_comb begin
        if (fast_clr_en) begin
            clr = acc.cnt_wr || acc.cnt_rd;
        end else begin
            clr = acc.flag_w1c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    // R8: a set event always leaves the flag high
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag);

    // R6: fast mode ignores write-one on the flag bit
    a_r6_fast_ignores_w1c: assert property (@(posedge clk) disable iff (rst)
        (fast_clr_en && flag && !acc.cnt_wr && !acc.cnt_rd) |=> flag);

    // R5: normal mode write-one clears
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (!fast_clr_en && acc.flag_w1c && !set_evt) |=> !flag);

    // R7: fast mode count access clears
    a_r7_access_clears: assert property (@(posedge clk) disable iff (rst)
        (fast_clr_en && (acc.cnt_wr || acc.cnt_rd) && !set_evt) |=> !flag);

endmodule

// File: rtl/mdc_regs.sv
module mdc_regs
    import mdc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      count,
    input  logic [W-1:0]      reload_val,
    input  logic              flag,
    output ctrl_t             ctrl,
    output access_t           acc,
    output logic [W-1:0]      load_data,
    output logic [W-1:0]      rdata
);

    reg_addr_e sel;

    assign sel          = reg_addr_e'(addr);
    assign load_data    = wdata;
    assign acc.cnt_wr   = wr_en && (sel == ADR_COUNT);
    assign acc.cnt_rd   = rd_en && (sel == ADR_COUNT);
    assign acc.flag_w1c = wr_en && (sel == ADR_FLAG) && wdata[FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && sel == ADR_CTRL) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            ADR_CTRL:   rdata[CTRL_W-1:0] = ctrl;
            ADR_FLAG:   rdata[FLAG_BIT]   = flag;
            ADR_COUNT:  rdata             = count;
            ADR_RELOAD: rdata             = reload_val;
        endcase
    end

    // R11: flag register read carries nothing but the flag bit
    a_r11_flag_read_clean: assert property (@(posedge clk) disable iff (rst)
        (sel == ADR_FLAG) |-> ($countones(rdata) == (flag ? 1 : 0)));

endmodule

// File: rtl/mdc_top.sv
module mdc_top
    import mdc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fast_clr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      count,
    output logic              flag,
    output logic              irq
);

    ctrl_t        ctrl;
    access_t      acc;
    logic [W-1:0] load_data;
    logic [W-1:0] reload_val;
    logic         tick;
    logic         zero_evt;

    mdc_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wdata      (wdata),
        .count      (count),
        .reload_val (reload_val),
        .flag       (flag),
        .ctrl       (ctrl),
        .acc        (acc),
        .load_data  (load_data),
        .rdata      (rdata)
    );

    mdc_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run),
        .restart (acc.cnt_wr),
        .div_sel (ctrl.div_sel),
        .tick    (tick)
    );

    mdc_counter #(.W(W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .load_wr     (acc.cnt_wr),
        .load_data   (load_data),
        .reload_mode (ctrl.reload_mode),
        .count       (count),
        .reload_val  (reload_val),
        .zero_evt    (zero_evt)
    );

    mdc_flag u_flag (
        .clk         (clk),
        .rst         (rst),
        .set_evt     (zero_evt),
        .fast_clr_en (fast_clr_en),
        .acc         (acc),
        .flag        (flag)
    );

    assign irq = flag && ctrl.irq_en;

    // R1: first cycle out of reset shows an idle block
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == '0 && !flag && !irq));

    // R10: no request without a pending flag
    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

    // R4: the flag only rises when the count has just reached zero
    a_r4_flag_rise_at_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> (count == '0));

endmodule

// File: tb/mdc_top_tb.sv
module mdc_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fast_clr_en = 1'b0;
    logic [1:0]   addr = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic [W-1:0] count;
    logic         flag;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdc_top #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .fast_clr_en(fast_clr_en), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .count(count), .flag(flag), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge; the access takes effect at the next rising edge
    task automatic wr(input logic [1:0] a, input int d);
        addr = a; wdata = W'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        addr = a; rd_en = 1'b1;
        #1 v = int'(rdata);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output int v);
        addr = a;
        #1 v = int'(rdata);
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int n;
        int e;
        wait_n(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 count", int'(count), 0);
        chk("R1 flag", int'(flag), 0);
        chk("R1 irq", int'(irq), 0);
        peek(2'd0, v);
        chk("R1 ctrl", v, 0);

        // R2/R3 divider sweep over every select code
        for (int p = 0; p < 4; p++) begin
            n = (p == 0) ? 1 : (p == 1) ? 4 : (p == 2) ? 8 : 16;
            wr(2'd0, p << 2);
            wr(2'd2, 20);
            peek(2'd3, v);
            chk("R3 reload readback", v, 20);
            wr(2'd0, (p << 2) | 1);
            for (int k = 0; k <= 40; k++) begin
                e = 20 - k / n;
                if (e < 0) e = 0;
                chk("R2 divided count", int'(count), e);
                @(negedge clk);
            end
            wr(2'd0, 0);
            wr(2'd1, 16'h0080);
        end

        // R3 load mid-run restarts the divider (divide by 4)
        wr(2'd2, 10);
        wr(2'd0, (1 << 2) | 1);
        wait_n(2);
        wr(2'd2, 7);
        wait_n(3);
        chk("R3 no step before N clocks", int'(count), 7);
        @(negedge clk);
        chk("R3 step after N clocks", int'(count), 6);

        // R12 halt
        wr(2'd0, 0);
        wr(2'd2, 9);
        wait_n(6);
        chk("R12 halted count", int'(count), 9);

        // R4/R9 single shot, load 3, divide by 1
        wr(2'd2, 3);
        wr(2'd1, 16'h0080);
        wr(2'd0, 1);
        wait_n(2);
        chk("R4 flag low before zero", int'(flag), 0);
        chk("R4 count one", int'(count), 1);
        @(negedge clk);
        chk("R4 count zero", int'(count), 0);
        chk("R4 flag set at zero", int'(flag), 1);
        wait_n(3);
        chk("R9 single shot parked", int'(count), 0);

        // R11 flag register readback
        peek(2'd1, v);
        chk("R11 flag register image", v, 16'h0080);

        // R10 interrupt gating
        chk("R10 irq masked", int'(irq), 0);
        wr(2'd0, 16'h0010);
        chk("R10 irq enabled", int'(irq), 1);
        wr(2'd0, 0);
        chk("R10 irq masked again", int'(irq), 0);

        // R5 write-zero no effect, write-one clears
        wr(2'd1, 16'h007F);
        chk("R5 write zero keeps flag", int'(flag), 1);
        wr(2'd1, 16'h0080);
        chk("R5 write one clears", int'(flag), 0);

        // R9 reload mode, load 3, divide by 1
        wr(2'd2, 3);
        wr(2'd0, 3);
        for (int k = 0; k < 12; k++) begin
            chk("R9 reload count", int'(count), 3 - (k % 4));
            chk("R9 reload flag", int'(flag), (k >= 3) ? 1 : 0);
            @(negedge clk);
        end
        wr(2'd0, 0);
        wr(2'd1, 16'h0080);

        // R8 write-one on the setting edge
        wr(2'd2, 3);
        wr(2'd0, 1);
        wait_n(2);
        wr(2'd1, 16'h0080);
        chk("R8 set beats write-one", int'(flag), 1);
        wr(2'd1, 16'h0080);
        chk("R5 later clear", int'(flag), 0);
        wr(2'd0, 0);

        // R6/R7 fast clear mode
        fast_clr_en = 1'b1;
        wr(2'd2, 2);
        wr(2'd0, 1);
        wait_n(2);
        chk("R4 flag set fast mode", int'(flag), 1);
        wr(2'd1, 16'h0080);
        chk("R6 write-one ignored", int'(flag), 1);
        rd(2'd2, v);
        chk("R7 count read clears", int'(flag), 0);
        wr(2'd0, 0);
        wr(2'd2, 2);
        wr(2'd0, 1);
        wait_n(2);
        chk("R4 flag set again", int'(flag), 1);
        wr(2'd2, 5);
        chk("R7 count write clears", int'(flag), 0);
        chk("R3 count write value", int'(count), 5);

        // R8 read clear on the setting edge
        wr(2'd0, 0);
        wr(2'd2, 3);
        wr(2'd0, 1);
        wait_n(2);
        rd(2'd2, v);
        chk("R8 set beats read clear", int'(flag), 1);
        chk("R7 read value before step", v, 1);
        wr(2'd0, 0);
        fast_clr_en = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule